// File: doc/BRIEF.md
# PC-Relative Store Sequencer

This block is a small bus-based processor slice that carries out one kind of instruction: a store whose target address is the program counter plus a signed 9-bit offset taken from the instruction word. The slice holds an instruction register, a program counter, an eight-entry register file, an address adder fed by two operand multiplexers, a small ALU with a pass-through operation, and the memory address and memory data registers. All of them meet on one internal bus, and only one source may drive that bus at a time. A small synchronous RAM inside the block receives the stored word.

A caller preloads the register file through a write port. It then presents an instruction word and a program counter value together with a one-cycle start request. The control unit steps through three states. In the first, the address adder forms PC plus the offset and the result is latched into the address register. In the second, the source register passes through the ALU onto the bus and into the data register. In the third, memory is enabled for a write. A one-cycle done pulse follows. A separate read port lets the caller inspect the RAM.

Top module: `pcs_store_unit`

## Requirements
- R1: While reset is applied, and after it is released with no start, `busy`, `done` and `mem_we` are all 0.
- R2: A start accepted at a clock edge makes `busy` high for the four following cycles. `mem_we` is high only in the third of them, and the whole store takes exactly three cycles after acceptance.
- R3: In the write cycle, `mem_addr` equals PC + sext(instr[8:0]) modulo 2^16. The PC and instruction are the values captured at acceptance.
- R4: The offset is sign extended by copying instr[8] into bits 15:9, so an offset of 9'h1FF yields PC - 1 and 9'h100 yields PC - 256.
- R5: In the write cycle, `mem_wdata` equals the register file entry selected by instr[11:9], as it was during the second cycle.
- R6: The address register is loaded only in the first cycle of the sequence and holds its value at every other edge.
- R7: The data register is loaded only in the second cycle, from the bus. The memory read path is not selected in that cycle.
- R8: At most one bus driver (the address mux gate or the ALU gate) is enabled in any cycle.
- R9: `done` is high for exactly one cycle, the cycle immediately after the write cycle.
- R10: A start request that arrives while `busy` is high is ignored. Captured values are unchanged, there is no second write and no second done pulse.
- R11: A start is accepted only when instr[15:12] equals 4'b0011. Any other value leaves `busy` low and memory unchanged.
- R12: When `rf_we` is high at a clock edge, `rf_wdata` is written into register `rf_waddr`. The next store that names that register writes that value.
- R13: The RAM stores the word at index `mem_addr[5:0]`. `rd_data` returns the word at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| instr_in | input | 16 | Instruction word captured at acceptance |
| pc_in | input | 16 | Program counter captured at acceptance |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 16 | Register file write data |
| rd_addr | input | 6 | RAM inspection read index |
| rd_data | output | 16 | RAM inspection read data, one cycle latency |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | RAM write strobe (write cycle) |
| mem_addr | output | 16 | Contents of the address register |
| mem_wdata | output | 16 | Contents of the data register |

## Verification
Every cycle, the assertions check the three-state order of the control unit, the single-driver rule on the bus, and that the address and data registers change only in their own cycles. They also check that done follows the write strobe by exactly one cycle. The numeric results can only be shown by the bench scenarios, which compare against a reference computed from the instruction fields. These results are the wrapped effective address, the sign-extended negative offsets, the stored register value and the RAM contents read back afterwards. The same holds for ignored starts during a busy sequence and for rejected opcodes.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int REG_IDX_W = 3;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam logic [3:0] STORE_OPCODE = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    A2_ZERO,
    A2_OFF6,
    A2_OFF9,
    A2_OFF11
  } a2_sel_e;

  typedef enum logic {
    A1_PC,
    A1_BASE
  } a1_sel_e;

  typedef enum logic {
    MM_ADDER,
    MM_VECTOR
  } mm_sel_e;

  typedef enum logic {
    S1_DST,
    S1_BASE
  } sr1_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_AND,
    ALU_NOT,
    ALU_PASSA
  } alu_op_e;

  typedef struct packed {
    a2_sel_e  a2;
    a1_sel_e  a1;
    mm_sel_e  mm;
    logic     gate_mm;
    logic     gate_alu;
    logic     ld_mar;
    sr1_sel_e sr1;
    alu_op_e  alu;
    logic     ld_mdr;
    logic     mio_en;
    logic     mem_wr;
  } ctrl_t;

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  opcode_ok,
  output ctrl_t ctl,
  output logic  accept,
  output logic  busy,
  output logic  done
);

  seq_state_e cur_q;
  seq_state_e nxt;

  // next-state
  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      ST_IDLE:  if (start && opcode_ok) nxt = ST_ADDR;
      ST_ADDR:  nxt = ST_DATA;
      ST_DATA:  nxt = ST_WRITE;
      ST_WRITE: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ST_IDLE;
    else        cur_q <= nxt;
  end

  // per-state control word: every signal of a state asserted together
  always_comb begin
    ctl.a2       = A2_ZERO;
    ctl.a1       = A1_PC;
    ctl.mm       = MM_ADDER;
    ctl.gate_mm  = 1'b0;
    ctl.gate_alu = 1'b0;
    ctl.ld_mar   = 1'b0;
    ctl.sr1      = S1_DST;
    ctl.alu      = ALU_ADD;
    ctl.ld_mdr   = 1'b0;
    ctl.mio_en   = 1'b0;
    ctl.mem_wr   = 1'b0;
    unique case (cur_q)
      ST_ADDR: begin
        ctl.a2      = A2_OFF9;
        ctl.a1      = A1_PC;
        ctl.mm      = MM_ADDER;
        ctl.gate_mm = 1'b1;
        ctl.ld_mar  = 1'b1;
      end
      ST_DATA: begin
        ctl.sr1      = S1_DST;
        ctl.alu      = ALU_PASSA;
        ctl.gate_alu = 1'b1;
        ctl.mio_en   = 1'b0;
        ctl.ld_mdr   = 1'b1;
      end
      ST_WRITE: begin
        ctl.mio_en = 1'b1;
        ctl.mem_wr = 1'b1;
      end
      default: ;
    endcase
  end

  assign accept = (cur_q == ST_IDLE) && start && opcode_ok;
  assign busy   = (cur_q != ST_IDLE);
  assign done   = (cur_q == ST_DONE);

  // R2: fixed three-cycle order after acceptance
  a_r2_addr_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q == ST_ADDR |=> cur_q == ST_DATA);
  a_r2_data_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q == ST_DATA |=> cur_q == ST_WRITE);
  a_r2_accept_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cur_q == ST_ADDR);
  // R10: while busy no new sequence starts
  a_r10_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_q != ST_DONE) |=> busy);
  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pcs_regfile.sv
module pcs_regfile #(
  parameter int DW    = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ra1,
  output logic [DW-1:0]    rd1,
  input  logic [IDX_W-1:0] ra2,
  output logic [DW-1:0]    rd2
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] regs_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) regs_q[waddr] <= wdata;
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];

endmodule

// File: rtl/pcs_sram.sv
module pcs_sram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] ra_q;
  logic [DW-1:0] rb_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    ra_q <= mem_q[ra_addr];
    rb_q <= mem_q[rb_addr];
  end

  assign ra_data = ra_q;
  assign rb_data = rb_q;

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctl,
  input  logic                 ld_ir,
  input  logic [DW-5:0]        ir_in,
  input  logic [DW-1:0]        pc_in,
  input  logic [DW-1:0]        rf_rd1,
  input  logic [DW-1:0]        rf_rd2,
  input  logic [DW-1:0]        mem_rdata,
  output logic [REG_IDX_W-1:0] sr1_idx,
  output logic [REG_IDX_W-1:0] sr2_idx,
  output logic [DW-1:0]        mar,
  output logic [DW-1:0]        mdr
);

  localparam int FW = DW - 4;

  logic [FW-1:0] ir_q;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] mar_q;
  logic [DW-1:0] mdr_q;

  logic [DW-1:0] off6, off9, off11;
  logic [DW-1:0] a1_val, a2_val, addr_sum;
  logic [DW-1:0] mm_val, alu_val, bus, mdr_in;

  // instruction field and program counter, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      pc_q <= '0;
    end else if (ld_ir) begin
      ir_q <= ir_in;
      pc_q <= pc_in;
    end
  end

  // offset sign extension: top field bit replicated upward
  assign off6  = {{(DW-6){ir_q[5]}},  ir_q[5:0]};
  assign off9  = {{(DW-9){ir_q[8]}},  ir_q[8:0]};
  assign off11 = {{(DW-11){ir_q[10]}}, ir_q[10:0]};

  assign sr1_idx = (ctl.sr1 == S1_DST) ? ir_q[11:9] : ir_q[8:6];
  assign sr2_idx = ir_q[2:0];

  always_comb begin
    unique case (ctl.a2)
      A2_ZERO:  a2_val = '0;
      A2_OFF6:  a2_val = off6;
      A2_OFF9:  a2_val = off9;
      A2_OFF11: a2_val = off11;
      default:  a2_val = '0;
    endcase
  end

  assign a1_val   = (ctl.a1 == A1_PC) ? pc_q : rf_rd1;
  assign addr_sum = a1_val + a2_val;  // wraps modulo 2**DW
  assign mm_val   = (ctl.mm == MM_ADDER) ? addr_sum : {{(DW-8){1'b0}}, ir_q[7:0]};

  always_comb begin
    unique case (ctl.alu)
      ALU_ADD:   alu_val = rf_rd1 + rf_rd2;
      ALU_AND:   alu_val = rf_rd1 & rf_rd2;
      ALU_NOT:   alu_val = ~rf_rd1;
      ALU_PASSA: alu_val = rf_rd1;
      default:   alu_val = rf_rd1;
    endcase
  end

  // shared bus: gated sources
  always_comb begin
    bus = '0;
    if (ctl.gate_mm)       bus = mm_val;
    else if (ctl.gate_alu) bus = alu_val;
  end

  // R8: single driver on the bus
  a_r8_one_bus_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.gate_mm, ctl.gate_alu}));

  assign mdr_in = ctl.mio_en ? mem_rdata : bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mar_q <= '0;
    else if (ctl.ld_mar) mar_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mdr_q <= '0;
    else if (ctl.ld_mdr) mdr_q <= mdr_in;
  end

  // R6: address register moves only on its load
  a_r6_mar_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld_mar |=> $stable(mar_q));
  // R7: data register moves only on its load, and is fed from the bus then
  a_r7_mdr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld_mdr |=> $stable(mdr_q));
  a_r7_mdr_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_mdr |-> !ctl.mio_en);

  assign mar = mar_q;
  assign mdr = mdr_q;

endmodule

// File: rtl/pcs_store_unit.sv
module pcs_store_unit
  import pcs_pkg::*;
#(
  parameter int DW     = 16,
  parameter int MEM_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-1:0]        instr_in,
  input  logic [DW-1:0]        pc_in,
  input  logic                 rf_we,
  input  logic [REG_IDX_W-1:0] rf_waddr,
  input  logic [DW-1:0]        rf_wdata,
  input  logic [MEM_AW-1:0]    rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_we,
  output logic [DW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata
);

  logic                 rst_ns;
  ctrl_t                ctl;
  logic                 accept;
  logic                 opcode_ok;
  logic [REG_IDX_W-1:0] sr1_idx, sr2_idx;
  logic [DW-1:0]        rf_rd1, rf_rd2;
  logic [DW-1:0]        mem_rdata;
  logic [DW-1:0]        mar, mdr;

  assign opcode_ok = (instr_in[DW-1:DW-4] == STORE_OPCODE);

  pcs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  pcs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (start),
    .opcode_ok (opcode_ok),
    .ctl       (ctl),
    .accept    (accept),
    .busy      (busy),
    .done      (done)
  );

  pcs_regfile #(.DW(DW), .IDX_W(REG_IDX_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (sr1_idx),
    .rd1   (rf_rd1),
    .ra2   (sr2_idx),
    .rd2   (rf_rd2)
  );

  pcs_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_ns),
    .ctl       (ctl),
    .ld_ir     (accept),
    .ir_in     (instr_in[DW-5:0]),
    .pc_in     (pc_in),
    .rf_rd1    (rf_rd1),
    .rf_rd2    (rf_rd2),
    .mem_rdata (mem_rdata),
    .sr1_idx   (sr1_idx),
    .sr2_idx   (sr2_idx),
    .mar       (mar),
    .mdr       (mdr)
  );

  assign mem_we = ctl.mio_en & ctl.mem_wr;

  pcs_sram #(.DW(DW), .AW(MEM_AW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mar[MEM_AW-1:0]),
    .wdata   (mdr),
    .ra_addr (mar[MEM_AW-1:0]),
    .ra_data (mem_rdata),
    .rb_addr (rd_addr),
    .rb_data (rd_data)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;

  // R9: done follows the write strobe by one cycle
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_we |=> done);
  // R2: write strobe only while busy, and never with done
  a_r2_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_we |-> (busy && !done));
  // R3: address presented to memory holds through the write edge
  a_r3_addr_stable_write: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_we |=> $stable(mem_addr));

endmodule

// File: tb/test_pcs_store_unit.sv
module test_pcs_store_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] instr_in;
  logic [15:0] pc_in;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data;
  logic        busy, done, mem_we;
  logic [15:0] mem_addr, mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [15:0] mdl_reg [8];
  logic [15:0] mdl_mem [64];
  bit          mdl_ok  [64];

  always #5 clk = ~clk;

  pcs_store_unit i_pcs_store_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_in(instr_in), .pc_in(pc_in),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  function automatic logic [15:0] f_ea(input logic [15:0] pc, input logic [15:0] ins);
    return pc + {{7{ins[8]}}, ins[8:0]};
  endfunction

  function automatic logic [15:0] f_st(input logic [2:0] sr, input logic [8:0] off);
    return {4'b0011, sr, off};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = idx; rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
    mdl_reg[idx] = val;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    if (mdl_ok[a]) chk(req, rd_data, mdl_mem[a]);
  endtask

  task automatic run_store(input logic [15:0] ins, input logic [15:0] pc);
    logic [15:0] ea;
    logic [15:0] dat;
    ea  = f_ea(pc, ins);
    dat = mdl_reg[ins[11:9]];
    @(negedge clk);
    start = 1'b1; instr_in = ins; pc_in = pc;
    @(negedge clk);
    start = 1'b0; instr_in = $urandom; pc_in = $urandom;
    chk("R2 busy cycle1", {15'd0, busy}, 16'd1);
    chk("R2 no write cycle1", {15'd0, mem_we}, 16'd0);
    @(negedge clk);
    chk("R2 no write cycle2", {15'd0, mem_we}, 16'd0);
    @(negedge clk);
    chk("R2 write cycle3", {15'd0, mem_we}, 16'd1);
    chk("R9 no done in write", {15'd0, done}, 16'd0);
    chk("R3 effective address", mem_addr, ea);
    chk("R5 stored data", mem_wdata, dat);
    @(negedge clk);
    chk("R9 done after write", {15'd0, done}, 16'd1);
    chk("R2 write ends", {15'd0, mem_we}, 16'd0);
    mdl_mem[ea[5:0]] = dat;
    mdl_ok[ea[5:0]]  = 1'b1;
    @(negedge clk);
    chk("R9 done one cycle", {15'd0, done}, 16'd0);
    chk("R2 busy ends", {15'd0, busy}, 16'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic [15:0] ins;
    logic [15:0] ea_a;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; instr_in = '0; pc_in = '0;
    rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0; rd_addr = '0;
    for (int i = 0; i < 64; i++) mdl_ok[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'd0, busy}, 16'd0);
    chk("R1 done in reset", {15'd0, done}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle busy", {15'd0, busy}, 16'd0);
    chk("R1 idle write", {15'd0, mem_we}, 16'd0);
    chk("R1 idle done", {15'd0, done}, 16'd0);

    // R12: register file load
    for (int r = 0; r < 8; r++) wr_reg(r[2:0], 16'hA000 + 16'(r * 16'h0111));

    // R4: offset 1FF gives PC-1
    run_store(f_st(3'd1, 9'h1FF), 16'h1000);
    rd_chk("R13 readback pc-1", 6'h3F);
    // R4: most negative offset
    run_store(f_st(3'd2, 9'h100), 16'h1040);
    rd_chk("R4 readback pc-256", 6'h00);
    // R3: wrap below zero and above top
    run_store(f_st(3'd3, 9'h1F0), 16'h0005);
    rd_chk("R3 readback wrap low", 6'h35);
    run_store(f_st(3'd4, 9'h0FF), 16'hFFF0);
    rd_chk("R3 readback wrap high", 6'h2F);
    // R12: update register then store it
    wr_reg(3'd4, 16'h5A5A);
    run_store(f_st(3'd4, 9'h002), 16'h0100);
    rd_chk("R12 new register value", 6'h02);

    // R11: wrong opcode rejected
    @(negedge clk);
    start = 1'b1; instr_in = {4'b0111, 3'd5, 9'h003}; pc_in = 16'h0010;
    @(negedge clk);
    start = 1'b0;
    chk("R11 bad opcode not busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R11 bad opcode no write", {15'd0, mem_we}, 16'd0);
    rd_chk("R11 memory unchanged", 6'h02);

    // R10: start while busy ignored; target of second request keeps old value
    ea_a = f_ea(16'h0200, f_st(3'd6, 9'h010));
    @(negedge clk);
    start = 1'b1; instr_in = f_st(3'd6, 9'h010); pc_in = 16'h0200;
    @(negedge clk);
    instr_in = f_st(3'd7, 9'h002); pc_in = 16'h0100;
    @(negedge clk);
    @(negedge clk);
    chk("R10 address of first request", mem_addr, ea_a);
    chk("R10 data of first request", mem_wdata, mdl_reg[6]);
    @(negedge clk);
    start = 1'b0;
    chk("R10 done once", {15'd0, done}, 16'd1);
    mdl_mem[ea_a[5:0]] = mdl_reg[6];
    mdl_ok[ea_a[5:0]]  = 1'b1;
    @(negedge clk);
    chk("R10 no restart", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R10 no second done", {15'd0, done}, 16'd0);
    rd_chk("R10 ignored target unchanged", 6'h02);
    rd_chk("R13 first request stored", ea_a[5:0]);

    // random stores
    for (int k = 0; k < 40; k++) begin
      if (k % 5 == 0) wr_reg(3'($urandom), 16'($urandom));
      ins = f_st(3'($urandom), 9'($urandom));
      run_store(ins, 16'($urandom));
      rd_chk("R13 random readback", 6'(f_ea(pc_in, ins)));
    end
    for (int a = 0; a < 64; a++) rd_chk("R13 sweep", a[5:0]);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule